// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Status Flags

This block is a 512-entry, 18-bit first-in first-out buffer between two clock domains that need not be related. A producer on the write clock pushes words with a write strobe. A consumer on the read clock always sees the oldest stored word on its data output, with no request needed to fetch it. A read strobe on the read clock drops that word and brings the next one forward.

Each side keeps its own binary pointer. Each pointer is sent to the other domain as a Gray code through a two-stage synchronizer. The full and half-full indications come from the write side. The empty indication comes from the read side. Each flag is conservative in its own domain: it can report full or empty for a few cycles after the real state has changed, but never the reverse.

A write-inhibit input lets neighbouring control logic stop words from being stored. An output-enable input, active low, sets a drive qualifier on the data output. One asynchronous active-low reset empties the buffer. Each domain releases that reset synchronously to its own clock.

Top module: `dual_clk_fwft_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released, the buffer holds no word: `full_n` is 1, `empty_n` is 0 and `half_full` is 0. This also holds when reset is applied while words are stored.
- R2: The buffer holds 512 words. `full_n` is 1 while 511 or fewer words are held, as seen in the write domain. It goes to 0 on the write edge that stores the 512th word.
- R3: A write strobe at a write-clock edge where `full_n` is 0 stores nothing. The stored contents and their order do not change.
- R4: `empty_n` is 0 when the read domain sees no stored word. A read strobe at a read-clock edge where `empty_n` is 0 removes nothing.
- R5: A word written into an empty buffer appears on `rd_data`, with `empty_n` at 1, by the third falling read-clock edge after the write edge. No read strobe is needed. Before that point, `empty_n` stays 0.
- R6: Words leave in the order they were written. A read strobe at a read-clock edge with `empty_n` at 1 removes the word shown, and the next word is shown after that edge.
- R7: `half_full` is 1 when the write domain counts 256 or more words held. It is 0 when it counts 255 or fewer.
- R8: While `wr_inhibit` is 1, a write strobe stores nothing.
- R9: `rd_data_drv` is the inverse of `out_en_n`. Changing `out_en_n` does not change the value on `rd_data`.
- R10: After a read from a full buffer, `full_n` stays 0 up to the falling read-clock edge that follows. It returns to 1 by the third falling write-clock edge after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, may be unrelated to `wr_clk` |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on `wr_clk` rising edge |
| wr_inhibit | input | 1 | Blocks storage while high |
| wr_data | input | 18 | Word to store |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| half_full | output | 1 | High when 256 or more words are held (write domain) |
| rd_en | input | 1 | Read strobe, sampled on `rd_clk` rising edge |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | 18 | Oldest stored word |
| rd_data_drv | output | 1 | High when `rd_data` is to be driven |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |

## Verification
The assertions assume that `rst_n` is low before the first rising edge of either clock. This puts every pointer and synchronizer stage in a defined state before any property is active. They also assume that strobes and write data change only between rising edges of their own clock. The bench meets both conditions: it holds reset low from time zero, drives every input on a falling edge, and gives the clocks 10 ns and 12 ns periods. With those periods, the rising edges of the two clocks never coincide, so the number of edges counted across the crossing is always the same.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  localparam int unsigned CODE_W = 16;
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t bin_to_gray(code_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic code_t gray_to_bin(code_t g);
    code_t b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      q       <= '0;
    end else begin
      stage_q <= d;
      q       <= stage_q;
    end
  end
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import fifo_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_inhibit,
  input  logic [AW:0]   rd_gray_s,
  output logic [AW-1:0] wr_addr,
  output logic          wr_we,
  output logic [AW:0]   wr_gray,
  output logic          full_n,
  output logic          half_full
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] bin_q, bin_d, rd_bin_s, level;
  logic          accept;

  always_comb begin
    rd_bin_s  = PW'(gray_to_bin(code_t'(rd_gray_s)));
    level     = bin_q - rd_bin_s;
    full_n    = (level != PW'(DEPTH));
    half_full = (level >= PW'(DEPTH / 2));
    accept    = wr_en & full_n & ~wr_inhibit;
    bin_d     = bin_q + PW'(accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      wr_gray <= '0;
    end else if (accept) begin
      bin_q   <= bin_d;
      wr_gray <= PW'(bin_to_gray(code_t'(bin_d)));
    end
  end

  assign wr_addr = bin_q[AW-1:0];
  assign wr_we   = accept;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH));
  // R3
  wr_hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |=> $stable(wr_gray));
  // R8
  wr_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit |=> $stable(wr_gray));
  // R7
  hf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> half_full);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wr_gray_s,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   rd_gray,
  output logic          empty_n
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] bin_q, bin_d, wr_bin_s;
  logic          pop;

  always_comb begin
    wr_bin_s = PW'(gray_to_bin(code_t'(wr_gray_s)));
    empty_n  = (wr_bin_s != bin_q);
    pop      = rd_en & empty_n;
    bin_d    = bin_q + PW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      rd_gray <= '0;
    end else if (pop) begin
      bin_q   <= bin_d;
      rd_gray <= PW'(bin_to_gray(code_t'(bin_d)));
    end
  end

  assign rd_addr = bin_q[AW-1:0];

  // R4
  rd_hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_gray));
  // R6
  rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty_n) |=> (bin_q == $past(bin_q) + PW'(1)));
endmodule

// File: rtl/dual_clk_fwft_fifo.sv
module dual_clk_fwft_fifo #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_inhibit,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  output logic              half_full,
  input  logic              rd_en,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_drv,
  output logic              empty_n
);
  localparam int unsigned PW = ADDR_W + 1;

  logic              wr_rst_n, rd_rst_n, wr_we;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;

  fifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
  fifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  fifo_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .wr_inhibit(wr_inhibit),
    .rd_gray_s(rd_gray_s), .wr_addr(wr_addr), .wr_we(wr_we),
    .wr_gray(wr_gray), .full_n(full_n), .half_full(half_full)
  );

  fifo_rd_ctl #(.AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wr_gray_s(wr_gray_s),
    .rd_addr(rd_addr), .rd_gray(rd_gray), .empty_n(empty_n)
  );

  fifo_gray_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  fifo_gray_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  fifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(wr_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign rd_data_drv = ~out_en_n;
endmodule

// File: tb/tb_dual_clk_fwft_fifo.sv
module tb_dual_clk_fwft_fifo;
  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        rst_n, wr_en, wr_inhibit, rd_en, out_en_n;
  logic [17:0] wr_data;
  logic        full_n, half_full, rd_data_drv, empty_n;
  logic [17:0] rd_data;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #5 wr_clk = ~wr_clk;
  always #6 rd_clk = ~rd_clk;

  dual_clk_fwft_fifo dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_inhibit(wr_inhibit), .wr_data(wr_data), .full_n(full_n),
    .half_full(half_full), .rd_en(rd_en), .out_en_n(out_en_n),
    .rd_data(rd_data), .rd_data_drv(rd_data_drv), .empty_n(empty_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [17:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_check(input logic [17:0] exp, input string tag);
    @(negedge rd_clk);
    check(empty_n == 1'b1, {tag, " empty_n"}, int'(empty_n), 1);
    check(rd_data == exp, {tag, " data"}, int'(rd_data), int'(exp));
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic flags_idle(input string tag);
    check(full_n == 1'b1, {tag, " full_n"}, int'(full_n), 1);
    check(empty_n == 1'b0, {tag, " empty_n"}, int'(empty_n), 0);
    check(half_full == 1'b0, {tag, " half_full"}, int'(half_full), 0);
  endtask

  task automatic t_reset();
    #3;
    flags_idle("R1 in reset");
    #20;
    @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
    flags_idle("R1 after release");
  endtask

  task automatic t_empty_read();
    repeat (3) begin
      @(negedge rd_clk); rd_en = 1'b1;
    end
    @(negedge rd_clk); rd_en = 1'b0;
    settle();
    check(empty_n == 1'b0, "R4 read when empty", int'(empty_n), 0);
  endtask

  task automatic t_fall_through();
    push(18'h0_1A5C);
    check(empty_n == 1'b0, "R5 not yet visible", int'(empty_n), 0);
    repeat (3) @(negedge rd_clk);
    check(empty_n == 1'b1, "R5 empty_n rises", int'(empty_n), 1);
    check(rd_data == 18'h0_1A5C, "R5 data falls through", int'(rd_data), 'h1A5C);
    pop_check(18'h0_1A5C, "R4 R6 single");
    settle();
    check(empty_n == 1'b0, "R6 empty after pop", int'(empty_n), 0);
  endtask

  task automatic t_order();
    logic [17:0] pat [5] = '{18'h2AAAA, 18'h15555, 18'h00000, 18'h3FFFF, 18'h12345};
    foreach (pat[i]) push(pat[i]);
    settle();
    foreach (pat[i]) pop_check(pat[i], "R6 order");
    settle();
    check(empty_n == 1'b0, "R6 drained", int'(empty_n), 0);
  endtask

  task automatic t_inhibit();
    wr_inhibit = 1'b1;
    push(18'h0_0BAD);
    push(18'h0_0BAE);
    wr_inhibit = 1'b0;
    settle();
    check(empty_n == 1'b0, "R8 inhibit blocks", int'(empty_n), 0);
    push(18'h0_0C0C);
    settle();
    pop_check(18'h0_0C0C, "R8 after inhibit");
    settle();
  endtask

  task automatic t_out_enable();
    push(18'h2_5A5A);
    settle();
    @(negedge rd_clk);
    out_en_n = 1'b1; #1;
    check(rd_data_drv == 1'b0, "R9 drive off", int'(rd_data_drv), 0);
    check(rd_data == 18'h2_5A5A, "R9 data kept off", int'(rd_data), 'h25A5A);
    out_en_n = 1'b0; #1;
    check(rd_data_drv == 1'b1, "R9 drive on", int'(rd_data_drv), 1);
    pop_check(18'h2_5A5A, "R9 data kept on");
    settle();
  endtask

  task automatic t_fill();
    for (int i = 0; i < 512; i++) begin
      push(18'(i));
      if (i == 254) check(half_full == 1'b0, "R7 255 held", int'(half_full), 0);
      if (i == 255) check(half_full == 1'b1, "R7 256 held", int'(half_full), 1);
      if (i == 510) check(full_n == 1'b1, "R2 511 held", int'(full_n), 1);
    end
    check(full_n == 1'b0, "R2 512 held", int'(full_n), 0);
    push(18'h3_FFFF);
    check(full_n == 1'b0, "R3 still full", int'(full_n), 0);
    settle();
    pop_check(18'h0, "R3 head");
    check(full_n == 1'b0, "R10 full_n held", int'(full_n), 0);
    repeat (3) @(negedge wr_clk);
    check(full_n == 1'b1, "R10 full_n released", int'(full_n), 1);
    for (int i = 1; i < 512; i++) pop_check(18'(i), "R3 R6 drain");
    settle();
    check(empty_n == 1'b0, "R3 extra word dropped", int'(empty_n), 0);
    check(half_full == 1'b0, "R7 drained", int'(half_full), 0);
  endtask

  task automatic t_reset_busy();
    push(18'h1); push(18'h2); push(18'h3);
    settle();
    @(negedge wr_clk);
    rst_n = 1'b0;
    #2;
    flags_idle("R1 busy reset");
    #20;
    @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
    flags_idle("R1 busy released");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_inhibit = 1'b0; rd_en = 1'b0;
    out_en_n = 1'b0; wr_data = '0;
    t_reset();
    t_empty_read();
    t_fall_through();
    t_order();
    t_inhibit();
    t_out_enable();
    t_fill();
    t_reset_busy();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule